// File: doc/BRIEF.md
# DMA Controller Command and Mask Unit

This block holds the controller-wide registers of a four-channel DMA engine: the command byte, one mode byte per channel, the status byte, whose upper half carries the pending requests and whose lower half carries the terminal-count flags, the mask byte, and the byte-pointer flip-flop. A host drives it through an 8-bit port. A 3-bit write function selects one of eight write operations, and a 3-bit read function selects which value appears on the read data bus.

Request bits are set and cleared in three ways: by software through the request write, by per-channel hold and release inputs, and by a master reset. The block scans the channels every cycle. It drives a service-enable vector that marks each channel that is requested and not masked, plus a one-hot pick of the lowest-numbered such channel. The address and count registers and the data path sit in neighbouring blocks. These blocks report terminal count through `tc_i` and toggle the byte pointer through `ptr_toggle_i`.

Top module: `dma_ctrl_regs`

## Requirements
- R1: Write function 0 loads `cmd_o` only when the data has no bit set outside bit 2, so only 0x00 and 0x04 are accepted. Any other value is dropped and leaves `cmd_o` unchanged.
- R2: Write function 1 is a software request. Data bits [1:0] pick channel c. Bit 2 set makes status bit c+4 one, and bit 2 clear makes it zero. Status bit c is always cleared by this write.
- R3: Write function 2 changes only mask bit c, where c is data bits [1:0], and sets it to data bit 2.
- R4: Write function 3 stores the whole data byte as the mode of channel c (data bits [1:0]). The mode outputs show mode bits [3:2] as transfer type, bit 4 as auto-init, bit 5 as decrement, and bits [7:6] as operating mode.
- R5: `ff_o` inverts on each cycle with `ptr_toggle_i` high. Write function 4 clears it, and this wins over a toggle in the same cycle.
- R6: Write function 5 clears `ff_o`, status and command and sets the mask to 0xFF. Modes are kept.
- R7: Write function 6 clears the whole mask. Write function 7 loads the mask from the data byte.
- R8: Read function 0 shows status. When `rd_en_i` is high at an edge with read function 0, status bits [3:0] are cleared at that edge, but a terminal count arriving at the same edge is kept. Read function 1 shows the mask. Read functions 2 to 7 return 0.
- R9: `svc_en_o[c]` is high exactly when mask bit c is 0 and status bit c+4 is 1. `svc_first_o` is the lowest-numbered bit of `svc_en_o`, or zero when none is set.
- R10: `hold_i[c]` sets status bit c+4 and `release_i[c]` clears it. Release wins over hold and over a software request in the same cycle. Write function 5 wins over both.
- R11: `tc_i[c]` sets status bit c. The bit stays set until a status read clears it, or until a request write or master reset that affects it.
- R12: After `rst_ni` the block has mask 0xFF, status, command and flip-flop at 0, and all modes at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_fn_i | input | 3 | Write function select |
| wr_data_i | input | 8 | Write data |
| rd_fn_i | input | 3 | Read function select |
| rd_en_i | input | 1 | Read strobe (clears terminal-count flags on status read) |
| rd_data_o | output | 8 | Read data for `rd_fn_i` |
| hold_i | input | 4 | Per-channel request hold |
| release_i | input | 4 | Per-channel request release |
| tc_i | input | 4 | Per-channel terminal-count event |
| ptr_toggle_i | input | 1 | Byte-pointer toggle from channel register access |
| svc_en_o | output | 4 | Channels eligible for service |
| svc_first_o | output | 4 | Lowest eligible channel, one-hot |
| cmd_o | output | 8 | Command register |
| ff_o | output | 1 | Byte-pointer flip-flop |
| mode_xfer_o | output | 8 | Transfer type, 2 bits per channel |
| mode_auto_o | output | 4 | Auto-init per channel |
| mode_dec_o | output | 4 | Address decrement per channel |
| mode_op_o | output | 8 | Operating mode, 2 bits per channel |

## Verification
The service scan is swept over all 256 pairings of the request and mask nibbles. This shows that a mask bit blocks only its own channel and that the first-pick tracks the lowest eligible channel. Every command byte and every mask byte is written, which separates the two accepted command values from the 254 rejected ones. Software requests are issued on each channel in both polarities, with terminal-count flags preset, so that damage to a neighbouring bit shows up. The bench also drives same-cycle collisions: hold with release, release with a software request, master reset with hold, and a status read with a new terminal count. These fix the stated precedence.

// File: rtl/dma_ctrl_pkg.sv
package dma_ctrl_pkg;
  typedef enum logic [2:0] {
    WF_CMD     = 3'd0,
    WF_SWREQ   = 3'd1,
    WF_MASK1   = 3'd2,
    WF_MODE    = 3'd3,
    WF_CLRFF   = 3'd4,
    WF_MRESET  = 3'd5,
    WF_UNMASK  = 3'd6,
    WF_MASKALL = 3'd7
  } wr_fn_e;

  typedef enum logic [2:0] {
    RF_STATUS = 3'd0,
    RF_MASK   = 3'd1
  } rd_fn_e;

  localparam logic [7:0] CMD_LEGAL = 8'h04;
endpackage

// File: rtl/dma_status_reg.sv
module dma_status_reg #(
  parameter int NCH  = 4,
  localparam int CH_W = $clog2(NCH),
  localparam int SW   = 2 * NCH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_clr_i,
  input  logic [NCH-1:0]  tc_i,
  input  logic            req_we_i,
  input  logic [CH_W-1:0] req_ch_i,
  input  logic            req_set_i,
  input  logic [NCH-1:0]  hold_i,
  input  logic [NCH-1:0]  release_i,
  input  logic            mreset_i,
  output logic [SW-1:0]   status_o
);
  logic [SW-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (rd_clr_i) st_d[NCH-1:0] = '0;
    st_d[NCH-1:0] = st_d[NCH-1:0] | tc_i;
    if (req_we_i) begin
      st_d[NCH + int'(req_ch_i)] = req_set_i;
      st_d[int'(req_ch_i)]       = 1'b0;
    end
    // release has the last word over hold and software request
    st_d[SW-1:NCH] = (st_d[SW-1:NCH] | hold_i) & ~release_i;
    if (mreset_i) st_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;

  assign status_o = st_q;
endmodule

// File: rtl/dma_mask_reg.sv
module dma_mask_reg #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            single_we_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic            set_i,
  input  logic            clr_all_i,
  input  logic            load_all_i,
  input  logic [DW-1:0]   data_i,
  input  logic            mreset_i,
  output logic [DW-1:0]   mask_o
);
  logic [DW-1:0] m_q, m_d;

  always_comb begin
    m_d = m_q;
    if (single_we_i) m_d[int'(ch_i)] = set_i;
    if (clr_all_i)   m_d = '0;
    if (load_all_i)  m_d = data_i;
    if (mreset_i)    m_d = '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) m_q <= '1;
    else         m_q <= m_d;

  assign mask_o = m_q;
endmodule

// File: rtl/dma_mode_bank.sv
module dma_mode_bank #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [DW-1:0]     data_i,
  output logic [NCH*DW-1:0] modes_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] mode_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                          mode_q <= '0;
      else if (we_i && ch_i == CH_W'(i))    mode_q <= data_i;
    assign modes_o[i*DW +: DW] = mode_q;
  end
endmodule

// File: rtl/dma_svc_scan.sv
module dma_svc_scan #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] mask_i,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] first_o
);
  logic [NCH:0] seen;
  assign en_o    = req_i & ~mask_i;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NCH; i++) begin : g_scan
    assign first_o[i]  = en_o[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | en_o[i];
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_ctrl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CH_W = $clog2(NCH),
  localparam int SW   = 2 * NCH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_fn_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [2:0]       rd_fn_i,
  input  logic             rd_en_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic [NCH-1:0]   hold_i,
  input  logic [NCH-1:0]   release_i,
  input  logic [NCH-1:0]   tc_i,
  input  logic             ptr_toggle_i,
  output logic [NCH-1:0]   svc_en_o,
  output logic [NCH-1:0]   svc_first_o,
  output logic [DW-1:0]    cmd_o,
  output logic             ff_o,
  output logic [2*NCH-1:0] mode_xfer_o,
  output logic [NCH-1:0]   mode_auto_o,
  output logic [NCH-1:0]   mode_dec_o,
  output logic [2*NCH-1:0] mode_op_o
);
  logic we_cmd, we_req, we_mask1, we_mode, we_clrff, we_mrst, we_unmask, we_maskall;
  logic [CH_W-1:0] sel_ch;
  logic            sel_bit;
  logic [SW-1:0]   status;
  logic [DW-1:0]   mask;
  logic [NCH*DW-1:0] modes;
  logic [DW-1:0]   cmd_q;
  logic            ff_q;

  assign we_cmd     = wr_en_i && wr_fn_i == WF_CMD;
  assign we_req     = wr_en_i && wr_fn_i == WF_SWREQ;
  assign we_mask1   = wr_en_i && wr_fn_i == WF_MASK1;
  assign we_mode    = wr_en_i && wr_fn_i == WF_MODE;
  assign we_clrff   = wr_en_i && wr_fn_i == WF_CLRFF;
  assign we_mrst    = wr_en_i && wr_fn_i == WF_MRESET;
  assign we_unmask  = wr_en_i && wr_fn_i == WF_UNMASK;
  assign we_maskall = wr_en_i && wr_fn_i == WF_MASKALL;
  assign sel_ch     = wr_data_i[CH_W-1:0];
  assign sel_bit    = wr_data_i[CH_W];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                       cmd_q <= '0;
    else if (we_mrst)                                  cmd_q <= '0;
    else if (we_cmd && (wr_data_i & ~DW'(CMD_LEGAL)) == '0) cmd_q <= wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                   ff_q <= 1'b0;
    else if (we_clrff || we_mrst)  ff_q <= 1'b0;
    else if (ptr_toggle_i)         ff_q <= ~ff_q;

  dma_status_reg #(.NCH(NCH)) u_status (
    .clk_i, .rst_ni,
    .rd_clr_i  (rd_en_i && rd_fn_i == RF_STATUS),
    .tc_i,
    .req_we_i  (we_req),
    .req_ch_i  (sel_ch),
    .req_set_i (sel_bit),
    .hold_i,
    .release_i,
    .mreset_i  (we_mrst),
    .status_o  (status)
  );

  dma_mask_reg #(.NCH(NCH), .DW(DW)) u_mask (
    .clk_i, .rst_ni,
    .single_we_i (we_mask1),
    .ch_i        (sel_ch),
    .set_i       (sel_bit),
    .clr_all_i   (we_unmask),
    .load_all_i  (we_maskall),
    .data_i      (wr_data_i),
    .mreset_i    (we_mrst),
    .mask_o      (mask)
  );

  dma_mode_bank #(.NCH(NCH), .DW(DW)) u_modes (
    .clk_i, .rst_ni,
    .we_i    (we_mode),
    .ch_i    (sel_ch),
    .data_i  (wr_data_i),
    .modes_o (modes)
  );

  dma_svc_scan #(.NCH(NCH)) u_scan (
    .req_i   (status[SW-1:NCH]),
    .mask_i  (mask[NCH-1:0]),
    .en_o    (svc_en_o),
    .first_o (svc_first_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign mode_xfer_o[2*i +: 2] = modes[i*DW+2 +: 2];
    assign mode_auto_o[i]        = modes[i*DW+4];
    assign mode_dec_o[i]         = modes[i*DW+5];
    assign mode_op_o[2*i +: 2]   = modes[i*DW+6 +: 2];
  end

  always_comb
    case (rd_fn_i)
      RF_STATUS: rd_data_o = DW'(status);
      RF_MASK:   rd_data_o = mask;
      default:   rd_data_o = '0;
    endcase

  assign cmd_o = cmd_q;
  assign ff_o  = ff_q;
endmodule

// File: rtl/dma_ctrl_regs_chk.sv
module dma_ctrl_regs_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_en_i,
  input logic [2:0]     wr_fn_i,
  input logic [DW-1:0]  wr_data_i,
  input logic [NCH-1:0] release_i,
  input logic           ptr_toggle_i,
  input logic [NCH-1:0] svc_en_o,
  input logic [NCH-1:0] svc_first_o,
  input logic [DW-1:0]  cmd_o,
  input logic           ff_o
);
  assert_cmd_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o & ~DW'(8'h04)) == '0);

  assert_cmd_reject_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_fn_i == 3'd0 && (wr_data_i & ~DW'(8'h04)) != '0) |=> $stable(cmd_o));

  assert_clr_ptr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_fn_i == 3'd4) |=> !ff_o);

  assert_toggle_ptr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_toggle_i && !(wr_en_i && (wr_fn_i == 3'd4 || wr_fn_i == 3'd5))) |=> ff_o != $past(ff_o));

  assert_mreset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_fn_i == 3'd5) |=> (cmd_o == '0 && svc_en_o == '0 && !ff_o));

  assert_first_pick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(svc_first_o) && (svc_first_o & ~svc_en_o) == '0 &&
    ((svc_en_o != '0) == (svc_first_o != '0)));

  assert_release_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i != '0) |=> (svc_en_o & $past(release_i)) == '0);
endmodule

bind dma_ctrl_regs dma_ctrl_regs_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_fn_i      (wr_fn_i),
  .wr_data_i    (wr_data_i),
  .release_i    (release_i),
  .ptr_toggle_i (ptr_toggle_i),
  .svc_en_o     (svc_en_o),
  .svc_first_o  (svc_first_o),
  .cmd_o        (cmd_o),
  .ff_o         (ff_o)
);

// File: tb/sim_dma_ctrl_regs.sv
`timescale 1ns/1ps
module sim_dma_ctrl_regs;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_fn_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_fn_i = '0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [3:0] hold_i = '0, release_i = '0, tc_i = '0;
  logic       ptr_toggle_i = 1'b0;
  logic [3:0] svc_en_o, svc_first_o, mode_auto_o, mode_dec_o;
  logic [7:0] cmd_o, mode_xfer_o, mode_op_o;
  logic       ff_o;

  int checks = 0, errors = 0;
  logic [7:0] m_status, m_mask, m_cmd;
  logic [7:0] m_mode [4];
  logic       m_ff;

  always #5 clk_i = ~clk_i;

  dma_ctrl_regs u0 (.*);

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one cycle; update the reference model after the edge
  task automatic step(logic we, logic [2:0] fn, logic [7:0] d, logic re,
                      logic [3:0] h, logic [3:0] r, logic [3:0] tc, logic tog);
    logic [7:0] s;
    @(negedge clk_i);
    wr_en_i = we; wr_fn_i = fn; wr_data_i = d; rd_en_i = re; rd_fn_i = 3'd0;
    hold_i = h; release_i = r; tc_i = tc; ptr_toggle_i = tog;
    @(posedge clk_i); #1;
    wr_en_i = 0; rd_en_i = 0; hold_i = 0; release_i = 0; tc_i = 0; ptr_toggle_i = 0;
    s = m_status;
    if (re) s[3:0] = 4'h0;
    s[3:0] = s[3:0] | tc;
    if (we && fn == 3'd1) begin s[4 + d[1:0]] = d[2]; s[d[1:0]] = 1'b0; end
    s[7:4] = (s[7:4] | h) & ~r;
    if (tog) m_ff = ~m_ff;
    if (we) case (fn)
      3'd0: if (d == 8'h00 || d == 8'h04) m_cmd = d;
      3'd2: m_mask[d[1:0]] = d[2];
      3'd3: m_mode[d[1:0]] = d;
      3'd4: m_ff = 1'b0;
      3'd5: begin m_ff = 1'b0; m_mask = 8'hFF; s = 8'h00; m_cmd = 8'h00; end
      3'd6: m_mask = 8'h00;
      3'd7: m_mask = d;
      default: ;
    endcase
    m_status = s;
  endtask

  task automatic wr(logic [2:0] fn, logic [7:0] d);
    step(1'b1, fn, d, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0);
  endtask

  task automatic check_all(string req);
    logic [3:0] en, first;
    en = m_status[7:4] & ~m_mask[3:0];
    first = 4'h0;
    for (int c = 3; c >= 0; c--) if (en[c]) first = 4'h1 << c;
    cmp(req, "svc_en", svc_en_o, en);
    cmp(req, "svc_first", svc_first_o, first);
    cmp(req, "cmd", cmd_o, m_cmd);
    cmp(req, "ff", ff_o, m_ff);
    for (int c = 0; c < 4; c++) begin
      cmp(req, "mode_xfer", mode_xfer_o[2*c +: 2], m_mode[c][3:2]);
      cmp(req, "mode_auto", mode_auto_o[c], m_mode[c][4]);
      cmp(req, "mode_dec", mode_dec_o[c], m_mode[c][5]);
      cmp(req, "mode_op", mode_op_o[2*c +: 2], m_mode[c][7:6]);
    end
    rd_fn_i = 3'd0; #0.5;
    cmp(req, "status read", rd_data_o, m_status);
    rd_fn_i = 3'd1; #0.5;
    cmp(req, "mask read", rd_data_o, m_mask);
    rd_fn_i = 3'd0;
  endtask

  initial begin
    m_status = 0; m_mask = 8'hFF; m_cmd = 0; m_ff = 0;
    for (int c = 0; c < 4; c++) m_mode[c] = 0;
    #12 rst_ni = 1'b1;
    // R12 reset state
    check_all("R12");
    for (int f = 2; f < 8; f++) begin
      rd_fn_i = 3'(f); #0.5;
      cmp("R8", "unused read", rd_data_o, 0);
    end
    // R1 every command byte
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, 8'(v));
      cmp("R1", "cmd", cmd_o, m_cmd);
      if (v == 3) wr(3'd0, 8'h04);
    end
    // R7 every mask byte, then clear
    for (int v = 0; v < 256; v++) begin
      wr(3'd7, 8'(v));
      rd_fn_i = 3'd1; #0.5;
      cmp("R7", "mask load", rd_data_o, v);
    end
    wr(3'd6, 8'h5A); check_all("R7");
    // R3 single-channel mask, all low codes with junk upper bits
    for (int v = 0; v < 8; v++) begin
      wr(3'd2, 8'(v) | 8'hA0); check_all("R3");
    end
    // R4 modes on every channel
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 64; p++) begin
        wr(3'd3, {6'(p + 17 * c), 2'(c)});
        if (p % 16 == 5) check_all("R4");
      end
    check_all("R4");
    // R11 + R2 software requests with terminal counts preset
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 2; s++) begin
        step(1'b0, 3'd0, 8'h0, 1'b0, 4'h0, 4'h0, 4'hF, 1'b0);
        check_all("R11");
        wr(3'd1, {5'h0, 1'(s), 2'(c)});
        check_all("R2");
      end
    // R8 status read clears terminal counts, new one survives
    step(1'b0, 3'd0, 8'h0, 1'b0, 4'h0, 4'h0, 4'h5, 1'b0);
    step(1'b0, 3'd0, 8'h0, 1'b1, 4'h0, 4'h0, 4'h2, 1'b0);
    check_all("R8");
    step(1'b0, 3'd0, 8'h0, 1'b1, 4'h0, 4'h0, 4'h0, 1'b0);
    check_all("R8");
    // R5 byte pointer
    step(1'b0, 3'd0, 8'h0, 1'b0, 4'h0, 4'h0, 4'h0, 1'b1); check_all("R5");
    step(1'b0, 3'd0, 8'h0, 1'b0, 4'h0, 4'h0, 4'h0, 1'b1); check_all("R5");
    step(1'b0, 3'd0, 8'h0, 1'b0, 4'h0, 4'h0, 4'h0, 1'b1);
    step(1'b1, 3'd4, 8'h0, 1'b0, 4'h0, 4'h0, 4'h0, 1'b1); check_all("R5");
    // R9 every request and mask nibble pairing
    for (int r = 0; r < 16; r++)
      for (int m = 0; m < 16; m++) begin
        wr(3'd7, {4'hC, 4'(m)});
        step(1'b0, 3'd0, 8'h0, 1'b0, 4'(r), ~4'(r), 4'h0, 1'b0);
        check_all("R9");
      end
    // R10 collisions
    wr(3'd6, 8'h0);
    step(1'b0, 3'd0, 8'h0, 1'b0, 4'hF, 4'h6, 4'h0, 1'b0); check_all("R10");
    step(1'b1, 3'd1, 8'h06, 1'b0, 4'h0, 4'h4, 4'h0, 1'b0); check_all("R10");
    step(1'b1, 3'd1, 8'h07, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0); check_all("R10");
    // R6 master reset against hold, ptr set, command set
    wr(3'd0, 8'h04);
    step(1'b0, 3'd0, 8'h0, 1'b0, 4'h0, 4'h0, 4'h9, 1'b1);
    step(1'b1, 3'd5, 8'h0, 1'b0, 4'hF, 4'h0, 4'h0, 1'b0);
    check_all("R6");
    check_all("R10");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule